// File: doc/BRIEF.md
# Sample Bus Pattern Checker

This block watches the parallel sample bus of a data converter and reports which bit lanes carried a wrong value. It is a bit-match tester for the input interface. During a test, the host sends the same eight-word pattern over and over. It raises SYNC together with the first word of each pass. The checker holds eight programmable expected words. It compares every received word against the entry the pattern position calls for, and it ORs any differing bit positions into a sticky error register.

Software loads the expected words and sets the test enable. It runs the host pattern for as long as it needs, then reads the error register. A clear strobe returns the register to zero. The sample word is 14 bits wide on the bus. Narrower 12-bit and 10-bit variants put their data on the upper lanes, and the unused low lanes are never compared. Before the first SYNC after enable, the checker does not know the pattern phase, so it compares nothing.

Top module: `pattern_bus_checker`

## Requirements
- R1: After a synchronous reset, `err_bits` reads zero and the checker is unlocked: nothing is compared until a SYNC arrives.
- R2: A word that arrives with `sync_in` high is compared against entry 0. Each later data clock moves to the next entry, and after entry 7 the index wraps back to entry 0 even without SYNC.
- R3: Entry k of the expected pattern is read from `pattern_words[14*k+13 : 14*k]`. A difference in bit i between `sample_in` and the selected entry sets `err_bits[i]` on the clock edge that captures the word.
- R4: Error bits are sticky. New mismatches are ORed in, and no bit returns to 0 except through clear or reset.
- R5: When `err_clear` is high on a clock edge, `err_bits` becomes zero after that edge. A mismatch in the same cycle is not recorded.
- R6: With parameter `DATA_W` set to 10, 12 or 14, only bits 13 down to 14-DATA_W are compared. The lower bits of `err_bits` always read 0.
- R7: While `test_en` is low, no comparison is made and `err_bits` keeps its value. Dropping the enable also discards the pattern lock.
- R8: After the enable is raised, words are ignored until the first SYNC, whatever their value.
- R9: A SYNC in the middle of a pass realigns the index so that the word carrying it is compared against entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; every rising edge captures one sample word |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Enables the pattern check |
| sync_in | input | 1 | Marks the first word of a pattern pass |
| sample_in | input | 14 | Received sample word, MSB-justified |
| pattern_words | input | 112 | Eight expected words; entry k in bits 14k+13 to 14k |
| err_clear | input | 1 | Clears the sticky error register |
| err_bits | output | 14 | Sticky per-lane mismatch flags |

## Verification
The hardest case to reach from the ports is the pattern-position wrap with no SYNC. Only a long, correct run past entry 7 shows whether entry 0 is selected again, and a mismatch placed on the ninth word after SYNC makes that visible. The stimulus table keeps each word correct for the position the requirements dictate and flips chosen lanes on selected rows. It also places a SYNC in the middle of a pass. This way an index that slips, wraps wrongly or ignores realignment shows up as errors on lanes that were never flipped. Directed steps then cover the lock behaviour. Mismatched words go out before SYNC and while the enable is low, and the bench checks that the register does not move.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int BUS_W   = 14;
    localparam int PAT_LEN = 8;
    localparam int IDX_W   = $clog2(PAT_LEN);

    typedef logic [BUS_W-1:0] word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } slot_t;

    function automatic word_t lane_mask(input int data_w);
        word_t m;
        for (int i = 0; i < BUS_W; i++) begin
            m[i] = (i >= BUS_W - data_w);
        end
        return m;
    endfunction

endpackage

// File: rtl/pbc_phase_tracker.sv
module pbc_phase_tracker
    import pbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  test_en,
    input  logic  sync_in,
    output slot_t slot,
    output logic  locked,
    output idx_t  next_idx
);

    always_ff @(posedge clk) begin
        if (rst || !test_en) begin
            locked   <= 1'b0;
            next_idx <= '0;
        end else if (sync_in) begin
            locked   <= 1'b1;
            next_idx <= idx_t'(1);
        end else if (locked) begin
            next_idx <= next_idx + idx_t'(1);
        end
    end

    always_comb begin
        slot.valid = test_en && (sync_in || locked);
        slot.idx   = sync_in ? '0 : next_idx;
    end

endmodule

// File: rtl/pbc_word_compare.sv
module pbc_word_compare
    import pbc_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic [PAT_LEN*BUS_W-1:0] pattern_words,
    input  word_t                    sample_in,
    input  slot_t                    slot,
    output word_t                    diff
);

    localparam word_t MASK = lane_mask(DATA_W);

    word_t entries [PAT_LEN];
    word_t chosen;

    for (genvar k = 0; k < PAT_LEN; k++) begin : g_unpack
        assign entries[k] = pattern_words[k*BUS_W +: BUS_W];
    end

    assign chosen = entries[slot.idx];

    for (genvar b = 0; b < BUS_W; b++) begin : g_lane
        if (MASK[b]) begin : g_used
            assign diff[b] = slot.valid && (sample_in[b] != chosen[b]);
        end else begin : g_unused
            assign diff[b] = 1'b0;
        end
    end

endmodule

// File: rtl/pbc_sticky_reg.sv
module pbc_sticky_reg
    import pbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  err_clear,
    input  word_t diff,
    output word_t err_bits
);

    always_ff @(posedge clk) begin
        if (rst || err_clear) begin
            err_bits <= '0;
        end else begin
            err_bits <= err_bits | diff;
        end
    end

endmodule

// File: rtl/pattern_bus_checker.sv
module pattern_bus_checker
    import pbc_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     test_en,
    input  logic                     sync_in,
    input  logic [BUS_W-1:0]         sample_in,
    input  logic [PAT_LEN*BUS_W-1:0] pattern_words,
    input  logic                     err_clear,
    output logic [BUS_W-1:0]         err_bits
);

    slot_t slot_w;
    logic  locked_w;
    idx_t  next_idx_w;
    word_t diff_w;

    pbc_phase_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .test_en  (test_en),
        .sync_in  (sync_in),
        .slot     (slot_w),
        .locked   (locked_w),
        .next_idx (next_idx_w)
    );

    pbc_word_compare #(.DATA_W(DATA_W)) u_cmp (
        .pattern_words (pattern_words),
        .sample_in     (sample_in),
        .slot          (slot_w),
        .diff          (diff_w)
    );

    pbc_sticky_reg u_err (
        .clk       (clk),
        .rst       (rst),
        .err_clear (err_clear),
        .diff      (diff_w),
        .err_bits  (err_bits)
    );

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker
    import pbc_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input logic  clk,
    input logic  rst,
    input logic  test_en,
    input logic  sync_in,
    input logic  err_clear,
    input word_t err_bits,
    input logic  locked_w,
    input idx_t  next_idx_w
);

    localparam word_t MASK = lane_mask(DATA_W);

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (err_bits == '0) && !locked_w);

    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        !err_clear |=> ((err_bits & $past(err_bits)) == $past(err_bits)));

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        err_clear |=> (err_bits == '0));

    a_r6_low_lanes_quiet: assert property (@(posedge clk) disable iff (rst)
        (err_bits & ~MASK) == '0);

    a_r7_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !err_clear) |=> $stable(err_bits));

    a_r7_disabled_unlock: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> !locked_w);

    a_r8_unlocked_hold: assert property (@(posedge clk) disable iff (rst)
        (!locked_w && !sync_in && !err_clear) |=> $stable(err_bits));

    a_r9_sync_realign: assert property (@(posedge clk) disable iff (rst)
        (test_en && sync_in) |=> (locked_w && next_idx_w == idx_t'(1)));

    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (test_en && locked_w && !sync_in) |=> (next_idx_w == $past(next_idx_w) + idx_t'(1)));

endmodule

bind pattern_bus_checker pbc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .test_en    (test_en),
    .sync_in    (sync_in),
    .err_clear  (err_clear),
    .err_bits   (err_bits),
    .locked_w   (locked_w),
    .next_idx_w (next_idx_w)
);

// File: tb/pattern_bus_checker_tb.sv
`timescale 1ns/1ps
module pattern_bus_checker_tb_top;

    localparam int W = 14;
    localparam logic [W-1:0] M10 = 14'h3FF0;

    logic clk = 1'b0;
    logic rst, test_en, sync_in, err_clear;
    logic [W-1:0] sample_in;
    logic [8*W-1:0] pattern_words;
    logic [W-1:0] err_full, err_narrow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_idx = 0;
    bit m_lock = 1'b0;
    logic [W-1:0] m_err = '0;

    always #10 clk = ~clk;

    pattern_bus_checker #(.DATA_W(14)) dut_i (
        .clk(clk), .rst(rst), .test_en(test_en), .sync_in(sync_in),
        .sample_in(sample_in), .pattern_words(pattern_words),
        .err_clear(err_clear), .err_bits(err_full)
    );

    pattern_bus_checker #(.DATA_W(10)) dut_n_i (
        .clk(clk), .rst(rst), .test_en(test_en), .sync_in(sync_in),
        .sample_in(sample_in), .pattern_words(pattern_words),
        .err_clear(err_clear), .err_bits(err_narrow)
    );

    function automatic logic [W-1:0] pat(input int k);
        return W'((k * 14'h1357) ^ 14'h2A5C);
    endfunction

    // Rows: {sync, lane flip mask}
    localparam logic [W:0] VEC [18] = '{
        {1'b1, 14'h0000}, {1'b0, 14'h0000}, {1'b0, 14'h0000}, {1'b0, 14'h0001},
        {1'b0, 14'h0000}, {1'b0, 14'h2000}, {1'b0, 14'h0000}, {1'b0, 14'h0000},
        {1'b1, 14'h0000}, {1'b0, 14'h0010}, {1'b0, 14'h0000}, {1'b1, 14'h0000},
        {1'b0, 14'h0000}, {1'b0, 14'h0000}, {1'b0, 14'h0000}, {1'b0, 14'h0000},
        {1'b0, 14'h0000}, {1'b0, 14'h0000}
    };

    task automatic check(input string tag);
        checks++;
        if (err_full !== m_err) begin
            errors++;
            $display("FAIL %s: err_bits actual %h expected %h", tag, err_full, m_err);
        end
        checks++;
        if (err_narrow !== (m_err & M10)) begin
            errors++;
            $display("FAIL %s (10-bit): err_bits actual %h expected %h", tag, err_narrow, m_err & M10);
        end
    endtask

    // Drive one word at a negedge, let one rising edge pass, return at the next negedge.
    task automatic step(input bit s, input logic [W-1:0] flip, input bit en, input bit clr);
        bit valid;
        int cur;
        valid = en && (s || m_lock);
        cur = s ? 0 : m_idx;
        test_en = en; sync_in = s; err_clear = clr;
        sample_in = pat(cur) ^ flip;
        @(posedge clk);
        @(negedge clk);
        if (clr) m_err = '0;
        else if (valid) m_err = m_err | flip;
        if (!en) begin m_lock = 1'b0; m_idx = 0; end
        else if (s) begin m_lock = 1'b1; m_idx = 1; end
        else if (m_lock) m_idx = (m_idx + 1) % 8;
        sync_in = 1'b0; err_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) pattern_words[k*W +: W] = pat(k);
        rst = 1'b1; test_en = 1'b0; sync_in = 1'b0; err_clear = 1'b0; sample_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state");

        // R8: enabled but unlocked, bad words ignored
        step(1'b0, 14'h3FFF, 1'b1, 1'b0);
        step(1'b0, 14'h1234, 1'b1, 1'b0);
        check("R8 ignored before first SYNC");

        // Table walk: R2 wrap, R3 lanes, R6 masking, R9 realign, R4 accumulation
        for (int r = 0; r < 18; r++) begin
            step(VEC[r][W], VEC[r][W-1:0], 1'b1, 1'b0);
            check($sformatf("R2/R3/R4/R6/R9 table row %0d", r));
        end
        // Wrap without SYNC: entry 0 reached at index wrap, flip lane 8
        while (m_idx != 0) step(1'b0, 14'h0000, 1'b1, 1'b0);
        step(1'b0, 14'h0100, 1'b1, 1'b0);
        check("R2 wrap to entry 0 without SYNC");

        // R5: clear wins over simultaneous mismatch
        step(1'b0, 14'h0800, 1'b1, 1'b1);
        check("R5 clear with concurrent mismatch");
        step(1'b0, 14'h0040, 1'b1, 1'b0);
        check("R3 new mismatch after clear");
        step(1'b0, 14'h0002, 1'b1, 1'b0);
        check("R4 accumulate second lane");

        // R7: disabled, mismatches ignored
        step(1'b0, 14'h3FFF, 1'b0, 1'b0);
        step(1'b1, 14'h3FFF, 1'b0, 1'b0);
        check("R7 disabled holds value");
        // R8 again: re-enabled, lock was dropped
        step(1'b0, 14'h0400, 1'b1, 1'b0);
        step(1'b0, 14'h0200, 1'b1, 1'b0);
        check("R7/R8 lock dropped, ignored until SYNC");
        step(1'b1, 14'h1000, 1'b1, 1'b0);
        check("R9 SYNC relocks at entry 0");

        // R1: reset in the middle of a run
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_err = '0; m_lock = 1'b0; m_idx = 0;
        check("R1 reset clears errors");
        step(1'b0, 14'h2000, 1'b1, 1'b0);
        check("R1 unlocked after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule